// File: doc/BRIEF.md
# Multi-Channel ADC Trigger Controller

This block sits in front of one shared 12-bit converter and serves up to sixteen input channels through a small memory-mapped register port. Software starts a conversion on a channel by writing a 0-to-1 change on that channel's trigger bit. The request is queued in a per-channel pending bit. The controller runs one conversion at a time and holds a global busy flag while the converter works. When the fixed sample latency has elapsed, it stores the converter's output in the channel's result word and raises that word's ready flag.

Before any request is accepted, a power-enable bit must be set and a settling interval must pass. When software lowers a trigger bit, the ready flag of that channel drops at once, so an old result is never taken for a new one. If power is removed during a conversion, the conversion stops, the queue is emptied and the busy flag falls. The analog side is reached through a channel-select output and a sample input that the conversion latch reads.

Top module: `adc_trig_ctrl`

## Requirements
- R1: After reset every register reads zero: trigger word, status, power word and all result words.
- R2: A 0-to-1 change of trigger bit n (word offset 0x04, bit n) on a powered, settled block converts channel n. The result word at 0x14+4n then holds the sample in bits 11:0 and bit 12 (ready) = 1.
- R3: Writing 0 to a trigger bit that was 1 clears bit 12 of that channel's result word in the next cycle. Bits 11:0 keep their value.
- R4: Status bit 0 (offset 0x10) reads 1 for exactly CONV_CYCLES consecutive cycles per conversion.
- R5: When several requests are pending, the lowest channel index is converted first.
- R6: Rewriting a trigger bit that is already 1 starts no conversion.
- R7: While power bit 14 (offset 0x94) is 0, and for SETTLE_CYCLES after it is set, trigger edges are dropped. After that they are accepted.
- R8: Clearing the power bit during a conversion stops it, empties all pending requests, drops busy and leaves every ready flag as it was.
- R9: Read data appears one cycle after the read strobe. Writes to status, result and unmapped words have no effect. Only bit 14 of the power word and the NUM_CH trigger bits are stored. Unmapped and unaligned addresses read zero.
- R10: A trigger edge that arrives while a conversion runs is queued and served after it, even if its channel index is lower.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| ana_sel | output | $clog2(NUM_CH) | Channel currently routed to the converter |
| ana_sample | input | DATA_W | Converter output, latched at the end of a conversion |

## Verification
Each conversion is checked with a converter stub that returns a value derived from the selected channel and a changeable seed. A changed seed shows whether a result is new or left over. Single triggers, a repeated write with no edge, and a falling write separate edge detection from level detection. A burst of three simultaneous edges tests the lowest-first order. A low-index edge that arrives mid-conversion shows that a running conversion is never pre-empted. Power-off, power-on during settling, and power loss mid-conversion check that requests are dropped or flushed while ready flags stay intact.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;
   localparam int OFF_TRIG  = 'h04;
   localparam int OFF_STAT  = 'h10;
   localparam int OFF_RES   = 'h14;
   localparam int OFF_MISC  = 'h94;
   localparam int BUSY_BIT  = 0;
   localparam int READY_BIT = 12;
   localparam int PWR_BIT   = 14;

   typedef enum logic [1:0] {
      S_OFF    = 2'd0,
      S_SETTLE = 2'd1,
      S_IDLE   = 2'd2,
      S_CONV   = 2'd3
   } seq_state_t;
endpackage

// File: rtl/adc_trig_arb.sv
module adc_trig_arb #(
   parameter int NUM_CH = 16,
   parameter int CH_W   = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] req,
   output logic [NUM_CH-1:0] grant,
   output logic [CH_W-1:0]   grant_idx,
   output logic              grant_vld
);
   logic [NUM_CH:0] blocked;

   assign blocked[0] = 1'b0;
   for (genvar i = 0; i < NUM_CH; i++) begin : g_chain
      assign grant[i]     = req[i] & ~blocked[i];
      assign blocked[i+1] = blocked[i] | req[i];
   end
   assign grant_vld = blocked[NUM_CH];

   always_comb begin
      grant_idx = '0;
      for (int i = 0; i < NUM_CH; i++)
         if (grant[i]) grant_idx = grant_idx | CH_W'(i);
   end

   // R5: exactly one winner whenever something is pending
   a_r5_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      (|req) |-> $onehot(grant));
   // R5: no pending request below the winner
   a_r5_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
      (|req) |-> ((req & (grant - NUM_CH'(1))) == '0));
endmodule

// File: rtl/adc_trig_seq.sv
module adc_trig_seq
   import adc_trig_pkg::*;
#(
   parameter int CONV_CYCLES   = 24,
   parameter int SETTLE_CYCLES = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_en,
   input  logic req,
   output logic start,
   output logic done,
   output logic busy,
   output logic accepting
);
   localparam int MAXC  = (CONV_CYCLES > SETTLE_CYCLES) ? CONV_CYCLES : SETTLE_CYCLES;
   localparam int CNT_W = $clog2(MAXC + 1);
   localparam logic [CNT_W-1:0] CONV_LAST   = CNT_W'(CONV_CYCLES - 1);
   localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYCLES - 1);

   seq_state_t       state;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= S_OFF;
         cnt   <= '0;
      end else if (!pwr_en) begin
         state <= S_OFF;
         cnt   <= '0;
      end else begin
         unique case (state)
            S_OFF: begin
               state <= S_SETTLE;
               cnt   <= '0;
            end
            S_SETTLE: begin
               if (cnt == SETTLE_LAST) begin
                  state <= S_IDLE;
                  cnt   <= '0;
               end else cnt <= cnt + 1'b1;
            end
            S_IDLE: begin
               if (req) begin
                  state <= S_CONV;
                  cnt   <= '0;
               end
            end
            S_CONV: begin
               if (cnt == CONV_LAST) begin
                  state <= S_IDLE;
                  cnt   <= '0;
               end else cnt <= cnt + 1'b1;
            end
            default: state <= S_OFF;
         endcase
      end
   end

   assign accepting = pwr_en && (state == S_IDLE || state == S_CONV);
   assign start     = pwr_en && (state == S_IDLE) && req;
   assign busy      = pwr_en && (state == S_CONV);
   assign done      = busy && (cnt == CONV_LAST);

   // R4: a conversion only begins from idle, never right after another edge of busy
   a_r4_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (busy || !pwr_en));
endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl
   import adc_trig_pkg::*;
#(
   parameter int NUM_CH        = 16,
   parameter int DATA_W        = 12,
   parameter int ADDR_W        = 8,
   parameter int CONV_CYCLES   = 24,
   parameter int SETTLE_CYCLES = 40
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [ADDR_W-1:0]         reg_addr,
   input  logic                      reg_wr,
   input  logic [31:0]               reg_wdata,
   input  logic                      reg_rd,
   output logic [31:0]               reg_rdata,
   output logic [$clog2(NUM_CH)-1:0] ana_sel,
   input  logic [DATA_W-1:0]         ana_sample
);
   localparam int CH_W = $clog2(NUM_CH);
   localparam logic [ADDR_W-1:0] A_TRIG  = ADDR_W'(OFF_TRIG);
   localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFF_STAT);
   localparam logic [ADDR_W-1:0] A_MISC  = ADDR_W'(OFF_MISC);
   localparam logic [ADDR_W-1:0] A_RES   = ADDR_W'(OFF_RES);
   localparam logic [ADDR_W-1:0] A_RES_E = ADDR_W'(OFF_RES + 4 * NUM_CH);

   if (NUM_CH < 2 || NUM_CH > 16) begin : g_bad_ch
      $error("NUM_CH must be 2..16");
   end
   if (DATA_W < 1 || DATA_W > READY_BIT) begin : g_bad_dw
      $error("DATA_W must be 1..12");
   end
   if (ADDR_W < 8) begin : g_bad_aw
      $error("ADDR_W must be at least 8");
   end
   if (CONV_CYCLES < 1 || SETTLE_CYCLES < 1) begin : g_bad_lat
      $error("latencies must be positive");
   end

   logic [NUM_CH-1:0] trig_q, pend_q, pend_n, ready_q;
   logic [DATA_W-1:0] data_q [NUM_CH];
   logic              pwr_q;
   logic [CH_W-1:0]   conv_ch;
   logic [NUM_CH-1:0] trig_new, trig_rise, trig_fall, grant;
   logic [CH_W-1:0]   grant_idx;
   logic              grant_vld, start, done, busy, accepting;
   logic              wr_trig, wr_misc, res_hit;
   logic [ADDR_W-1:0] res_off;
   logic [CH_W-1:0]   res_idx;
   logic [31:0]       rd_mux;
   logic              unused_bits;

   assign wr_trig   = reg_wr && (reg_addr == A_TRIG);
   assign wr_misc   = reg_wr && (reg_addr == A_MISC);
   assign trig_new  = reg_wdata[NUM_CH-1:0];
   assign trig_rise = wr_trig ? (trig_new & ~trig_q) : '0;
   assign trig_fall = wr_trig ? (~trig_new & trig_q) : '0;
   assign unused_bits = ^{reg_wdata, res_off};

   adc_trig_arb #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_arb (
      .clk(clk), .rst_n(rst_n), .req(pend_q),
      .grant(grant), .grant_idx(grant_idx), .grant_vld(grant_vld)
   );

   adc_trig_seq #(.CONV_CYCLES(CONV_CYCLES), .SETTLE_CYCLES(SETTLE_CYCLES)) u_seq (
      .clk(clk), .rst_n(rst_n), .pwr_en(pwr_q), .req(grant_vld),
      .start(start), .done(done), .busy(busy), .accepting(accepting)
   );

   always_comb begin
      pend_n = pend_q;
      if (start)     pend_n = pend_n & ~grant;
      if (accepting) pend_n = pend_n | trig_rise;
      if (!pwr_q)    pend_n = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig_q  <= '0;
         pend_q  <= '0;
         pwr_q   <= 1'b0;
         conv_ch <= '0;
      end else begin
         pend_q <= pend_n;
         if (wr_trig) trig_q <= trig_new;
         if (wr_misc) pwr_q  <= reg_wdata[PWR_BIT];
         if (start)   conv_ch <= grant_idx;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ready_q <= '0;
         for (int c = 0; c < NUM_CH; c++) data_q[c] <= '0;
      end else begin
         for (int c = 0; c < NUM_CH; c++) begin
            if (done && conv_ch == CH_W'(c)) begin
               ready_q[c] <= 1'b1;
               data_q[c]  <= ana_sample;
            end
            if (trig_fall[c]) ready_q[c] <= 1'b0;
         end
      end
   end

   assign ana_sel = conv_ch;

   assign res_off = reg_addr - A_RES;
   assign res_idx = res_off[CH_W+1:2];
   assign res_hit = (reg_addr >= A_RES) && (reg_addr < A_RES_E) && (res_off[1:0] == 2'b00);

   always_comb begin
      rd_mux = '0;
      if (reg_addr == A_TRIG)      rd_mux[NUM_CH-1:0] = trig_q;
      else if (reg_addr == A_STAT) rd_mux[BUSY_BIT]   = busy;
      else if (reg_addr == A_MISC) rd_mux[PWR_BIT]    = pwr_q;
      else if (res_hit) begin
         rd_mux[READY_BIT]   = ready_q[res_idx];
         rd_mux[DATA_W-1:0]  = data_q[res_idx];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      reg_rdata <= '0;
      else if (reg_rd) reg_rdata <= rd_mux;
      else             reg_rdata <= '0;
   end

   // R2: a ready flag only rises on the cycle after a conversion completes
   a_r2_ready_from_done: assert property (@(posedge clk) disable iff (!rst_n)
      (|(ready_q & ~$past(ready_q))) |-> $past(done));
   // R3: a falling trigger write leaves that channel's ready flag low
   a_r3_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (|trig_fall) |=> ((ready_q & $past(trig_fall)) == '0));
   // R8: without power the request queue is flushed
   a_r8_flush_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_q |=> (pend_q == '0));
   // R7: nothing is queued while edges are not accepted
   a_r7_no_queue_unsettled: assert property (@(posedge clk) disable iff (!rst_n)
      !accepting |=> (pend_q == '0));
endmodule

// File: tb/adc_trig_ctrl_tb.sv
module adc_trig_ctrl_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NUM_CH = 16;
   localparam int CONV   = 24;
   localparam int SETTLE = 40;
   localparam logic [7:0] A_TRIG = 8'h04, A_STAT = 8'h10, A_MISC = 8'h94;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [3:0]  ana_sel;
   logic [11:0] ana_sample;
   logic [11:0] seed = 12'h0A5;
   logic [31:0] trig_sh = '0;
   int checks = 0, failures = 0, cyc = 0;
   bit done_flag = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   // converter stub: value depends on selected channel and current seed
   assign ana_sample = seed + 12'({8'd0, ana_sel} * 12'h111);

   adc_trig_ctrl #(.NUM_CH(NUM_CH), .DATA_W(12), .ADDR_W(8),
                   .CONV_CYCLES(CONV), .SETTLE_CYCLES(SETTLE)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
      .ana_sel(ana_sel), .ana_sample(ana_sample)
   );

   function automatic logic [31:0] res_word(input int ch, input logic [11:0] s, input bit rdy);
      logic [11:0] v;
      v = s + 12'(ch * 'h111);
      return {19'd0, rdy, v};
   endfunction

   function automatic logic [7:0] res_addr(input int ch);
      return 8'(8'h14 + 4 * ch);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
      if (a == A_TRIG) trig_sh = d & 32'hFFFF;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [31:0] d;
      rd(A_TRIG, d); chk("R1 trig", d, 0);
      rd(A_STAT, d); chk("R1 status", d, 0);
      rd(A_MISC, d); chk("R1 power", d, 0);
      rd(res_addr(0), d);  chk("R1 result0", d, 0);
      rd(res_addr(15), d); chk("R1 result15", d, 0);
   endtask

   task automatic t_power_gate;
      logic [31:0] d;
      wr(A_TRIG, 32'h10); idle(CONV + 10);
      rd(res_addr(4), d); chk("R7 unpowered edge dropped", d, 0);
      rd(A_STAT, d);      chk("R7 unpowered not busy", d, 0);
      wr(A_TRIG, 0);
      wr(A_MISC, 32'h4000);
      wr(A_TRIG, 32'h10); idle(SETTLE + CONV + 10);
      rd(res_addr(4), d); chk("R7 settling edge dropped", d, 0);
      wr(A_TRIG, 0);
      wr(A_TRIG, 32'h10); idle(CONV + 10);
      rd(res_addr(4), d); chk("R7 settled edge accepted", d, res_word(4, seed, 1));
   endtask

   task automatic t_single;
      logic [31:0] d;
      int ones;
      wr(A_TRIG, 0);
      rd(res_addr(4), d); chk("R3 ch4 ready dropped", d, res_word(4, seed, 0));
      seed = 12'h100;
      wr(A_TRIG, 32'h20);
      reg_addr = A_STAT; reg_rd = 1'b1;
      ones = 0;
      for (int i = 0; i < CONV + 8; i++) begin
         @(negedge clk);
         if (reg_rdata[0]) ones++;
      end
      reg_rd = 1'b0;
      chk("R4 busy cycles", ones, CONV);
      rd(res_addr(5), d); chk("R2 ch5 result", d, res_word(5, seed, 1));
   endtask

   task automatic t_no_edge;
      logic [31:0] d;
      logic [11:0] old;
      wr(A_TRIG, 32'hA0); idle(CONV + 10);
      rd(res_addr(7), d); chk("R2 ch7 result", d, res_word(7, seed, 1));
      old = seed; seed = 12'h3C0;
      wr(A_TRIG, 32'hA0); idle(CONV + 10);
      rd(res_addr(7), d); chk("R6 level write no conversion", d, res_word(7, old, 1));
      seed = old;
   endtask

   task automatic t_clear;
      logic [31:0] d;
      wr(A_TRIG, 32'h80);
      rd(res_addr(5), d); chk("R3 ch5 ready cleared, data kept", d, res_word(5, seed, 0));
      rd(res_addr(7), d); chk("R3 ch7 untouched", d, res_word(7, seed, 1));
   endtask

   task automatic t_priority;
      logic [31:0] d;
      int seq [4];
      int n = 0;
      logic [3:0] last;
      seed = 12'h200;
      last = ana_sel;
      wr(A_TRIG, trig_sh | 32'h1208);
      for (int i = 0; i < 4 * (CONV + 1) + 10; i++) begin
         @(negedge clk);
         if (ana_sel != last) begin
            if (n < 4) seq[n] = int'(ana_sel);
            n++;
            last = ana_sel;
         end
      end
      chk("R5 number served", n, 3);
      chk("R5 first", seq[0], 3);
      chk("R5 second", seq[1], 9);
      chk("R5 third", seq[2], 12);
      rd(res_addr(3), d);  chk("R5 ch3 data", d, res_word(3, seed, 1));
      rd(res_addr(12), d); chk("R5 ch12 data", d, res_word(12, seed, 1));
   endtask

   task automatic t_queue;
      logic [31:0] d;
      int seq [4];
      int n = 0;
      logic [3:0] last;
      seed = 12'h055;
      last = ana_sel;
      fork
         begin
            wr(A_TRIG, trig_sh | 32'h2);
            idle(3);
            wr(A_TRIG, trig_sh | 32'h1);
         end
         begin
            for (int i = 0; i < 3 * (CONV + 1) + 10; i++) begin
               @(negedge clk);
               if (ana_sel != last) begin
                  if (n < 4) seq[n] = int'(ana_sel);
                  n++;
                  last = ana_sel;
               end
            end
         end
      join
      chk("R10 number served", n, 2);
      chk("R10 running first", seq[0], 1);
      chk("R10 queued after", seq[1], 0);
      rd(res_addr(0), d); chk("R10 ch0 data", d, res_word(0, seed, 1));
   endtask

   task automatic t_abort;
      logic [31:0] d;
      wr(A_TRIG, trig_sh | 32'h44);
      idle(3);
      wr(A_MISC, 0);
      rd(A_STAT, d);      chk("R8 busy dropped", d, 0);
      rd(res_addr(2), d); chk("R8 aborted ch2 not ready", d, 0);
      rd(res_addr(7), d); chk("R8 ch7 ready kept", d, res_word(7, 12'h100, 1));
      wr(A_MISC, 32'h4000);
      idle(SETTLE + 3 * CONV + 20);
      rd(res_addr(6), d); chk("R8 ch6 request flushed", d, 0);
      rd(res_addr(2), d); chk("R8 ch2 request flushed", d, 0);
      rd(A_STAT, d);      chk("R8 idle after repower", d, 0);
   endtask

   task automatic t_ro;
      logic [31:0] d;
      wr(A_STAT, 32'hFFFF_FFFF);
      rd(A_STAT, d);      chk("R9 status read-only", d, 0);
      wr(res_addr(3), 32'hFFFF_FFFF);
      rd(res_addr(3), d); chk("R9 result read-only", d, res_word(3, 12'h200, 1));
      wr(8'h08, 32'hFFFF_FFFF);
      rd(8'h08, d);       chk("R9 unmapped reads zero", d, 0);
      rd(8'h15, d);       chk("R9 unaligned reads zero", d, 0);
      rd(8'h54, d);       chk("R9 beyond last channel", d, 0);
      wr(A_MISC, 32'hFFFF_FFFF);
      rd(A_MISC, d);      chk("R9 power word bits", d, 32'h4000);
      wr(A_TRIG, 32'hFFFF_FFFF);
      rd(A_TRIG, d);      chk("R9 trigger width", d, 32'h0000_FFFF);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done_flag) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=<150000", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(2);
      t_reset();
      t_power_gate();
      t_single();
      t_no_edge();
      t_clear();
      t_priority();
      t_queue();
      t_abort();
      t_ro();
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule